// File: doc/BRIEF.md
# Fully Associative Victim Buffer

This block is a small side store on the miss path of a direct-mapped or low-associativity cache. Each block the cache throws out is handed to the buffer together with its full block address. When the cache misses, it probes the buffer with the missing block address before asking the next level. If the probe hits, the block returns to the cache and the block the cache displaces takes the freed slot in the same cycle. In effect, the buffer lends a few extra ways to whichever sets need them at the moment.

No slot is tied to a cache index, so each slot keeps the whole block address and every slot is compared in parallel. Slots are kept in age order. When the buffer is full, an insert pushes out the oldest block on an eviction port. That port is where a write-back path to the next level would attach.

Top module: `victim_buffer`

## Requirements
- R1: After reset the buffer holds no blocks: every probe misses and `ev_valid` is 0 until an insert into a full buffer occurs.
- R2: While `lk_valid` is 1 and `lk_addr` equals the full address of a held block, `lk_hit` is 1 and `lk_data` shows that block's data in the same cycle, with no clock edge in between.
- R3: A probe changes nothing. It does not alter the contents of the buffer or their age order.
- R4: An insert (`ins_valid`=1) of a new address into a buffer that is not full stores the block as the newest entry and produces no eviction. A lookup in the cycle of the insert still sees the old contents.
- R5: An insert of a new address into a full buffer (NUM_ENTRIES blocks held) drops the oldest held block. On the next cycle only, `ev_valid` is 1 and `ev_addr` and `ev_data` carry the dropped block.
- R6: An insert whose address matches a held block replaces that block's data and makes it the newest entry. The number of held blocks does not change and no eviction occurs.
- R7: A swap happens when `ins_valid`, `swap` and `lk_hit` are all 1 in the same cycle. In that case `swap_ack` is 1 in that cycle. At the edge the hit block leaves the buffer and the incoming victim is stored as the newest entry, with no change in the number of held blocks and no eviction.
- R8: When `ins_valid` and `swap` are 1 but the probe misses, `swap_ack` is 0 and the victim is handled as an ordinary insert (R4, R5, R6).
- R9: Matching uses every bit of the block address, and any slot may hold any address. Two addresses that differ in only one bit are held side by side.
- R10: While `lk_valid` is 0, `lk_hit` and `swap_ack` are 0 whatever `lk_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Block evicted from the cache is offered this cycle |
| swap | input | 1 | The offered block is the partner of this cycle's probe |
| ins_addr | input | ADDR_W | Full block address of the offered block |
| ins_data | input | DATA_W | Data of the offered block |
| lk_valid | input | 1 | Probe request from the cache miss path |
| lk_addr | input | ADDR_W | Full block address probed |
| lk_hit | output | 1 | Probe found the block |
| lk_data | output | DATA_W | Data of the found block, zero on a miss |
| swap_ack | output | 1 | Swap accepted this cycle |
| ev_valid | output | 1 | Oldest block dropped at the previous edge |
| ev_addr | output | ADDR_W | Address of the dropped block |
| ev_data | output | DATA_W | Data of the dropped block |

## Verification
`lk_hit`, `lk_data` and `swap_ack` are combinational on the stored state, so the bench checks them 1 ns after it drives inputs on the falling edge, before the rising edge that commits the cycle. A change to the stored state made by an insert or swap shows up in probes from the next cycle onward. The eviction outputs pass through one register. Each table row therefore holds the eviction that the previous row caused, and the bench checks it on the falling edge before it drives that row. This catches both a missing pulse and a pulse that lasts a second cycle.

// File: rtl/vb_pkg.sv
package vb_pkg;

   // kind of state change committed at the next edge
   typedef enum logic [1:0] {
      VB_HOLD    = 2'd0,  // no change
      VB_APPEND  = 2'd1,  // new block placed after the youngest entry
      VB_REPLACE = 2'd2,  // one entry removed, new block appended
      VB_ROTATE  = 2'd3   // oldest dropped, new block appended
   } vb_op_e;

   function automatic int vb_bits(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
   parameter int N      = 8,
   parameter int ADDR_W = 32
) (
   input  logic                       en,
   input  logic [ADDR_W-1:0]          key,
   input  logic [N-1:0]               vld,
   input  logic [N-1:0][ADDR_W-1:0]   tags,
   output logic [N-1:0]               hit_vec
);

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_vec[i] = en & vld[i] & (tags[i] == key);
   end

endmodule

// File: rtl/vb_enc.sv
module vb_enc #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign any = |vec;

endmodule

// File: rtl/vb_queue.sv
module vb_queue #(
   parameter int N      = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int IDX_W  = 3,
   parameter int CNT_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  vb_pkg::vb_op_e            op,
   input  logic [IDX_W-1:0]          rm_idx,
   input  logic [ADDR_W-1:0]         new_addr,
   input  logic [DATA_W-1:0]         new_data,
   output logic [N-1:0][ADDR_W-1:0]  q_addr,
   output logic [N-1:0][DATA_W-1:0]  q_data,
   output logic [N-1:0]              q_vld,
   output logic [CNT_W-1:0]          q_cnt
);

   import vb_pkg::*;

   logic [N-1:0][ADDR_W-1:0] addr_d;
   logic [N-1:0][DATA_W-1:0] data_d;
   logic [CNT_W-1:0]         cnt_d;
   logic                     shift;
   logic [IDX_W-1:0]         low;
   logic [IDX_W-1:0]         tail;

   // entry 0 is the oldest, entry q_cnt-1 the youngest
   assign shift = (op == VB_REPLACE) || (op == VB_ROTATE);
   assign low   = (op == VB_REPLACE) ? rm_idx : '0;
   assign tail  = shift ? IDX_W'(q_cnt - CNT_W'(1)) : IDX_W'(q_cnt);

   for (genvar i = 0; i < N; i++) begin : g_slot
      assign q_vld[i] = (CNT_W'(i) < q_cnt);
      if (i < N - 1) begin : g_mid
         always_comb begin
            addr_d[i] = q_addr[i];
            data_d[i] = q_data[i];
            if (op != VB_HOLD && IDX_W'(i) == tail) begin
               addr_d[i] = new_addr;
               data_d[i] = new_data;
            end else if (shift && IDX_W'(i) >= low && IDX_W'(i) < tail) begin
               addr_d[i] = q_addr[i+1];
               data_d[i] = q_data[i+1];
            end
         end
      end else begin : g_last
         always_comb begin
            addr_d[i] = q_addr[i];
            data_d[i] = q_data[i];
            if (op != VB_HOLD && IDX_W'(i) == tail) begin
               addr_d[i] = new_addr;
               data_d[i] = new_data;
            end
         end
      end
   end

   assign cnt_d = (op == VB_APPEND) ? q_cnt + CNT_W'(1) : q_cnt;

   always_ff @(posedge clk) begin
      q_addr <= addr_d;
      q_data <= data_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_cnt <= '0;
      else        q_cnt <= cnt_d;
   end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
   parameter int NUM_ENTRIES = 8,
   parameter int ADDR_W      = 26,
   parameter int DATA_W      = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic              swap,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [DATA_W-1:0] ins_data,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   output logic              swap_ack,
   output logic              ev_valid,
   output logic [ADDR_W-1:0] ev_addr,
   output logic [DATA_W-1:0] ev_data
);

   import vb_pkg::*;

   localparam int IDX_W = vb_bits(NUM_ENTRIES);
   localparam int CNT_W = vb_bits(NUM_ENTRIES + 1);

   if (NUM_ENTRIES < 2) begin : g_bad_n
      $error("victim_buffer: NUM_ENTRIES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("victim_buffer: address and data widths must be positive");
   end

   logic [NUM_ENTRIES-1:0][ADDR_W-1:0] q_addr;
   logic [NUM_ENTRIES-1:0][DATA_W-1:0] q_data;
   logic [NUM_ENTRIES-1:0]             q_vld;
   logic [CNT_W-1:0]                   cnt_q;
   logic [NUM_ENTRIES-1:0]             lk_vec;
   logic [NUM_ENTRIES-1:0]             dup_vec;
   logic [IDX_W-1:0]                   lk_idx;
   logic [IDX_W-1:0]                   dup_idx;
   logic                               lk_any;
   logic                               dup_any;
   logic                               full;
   vb_op_e                             op;
   logic [IDX_W-1:0]                   rm_idx;

   vb_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
      .en(lk_valid), .key(lk_addr), .vld(q_vld), .tags(q_addr), .hit_vec(lk_vec)
   );

   vb_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_dup_match (
      .en(ins_valid), .key(ins_addr), .vld(q_vld), .tags(q_addr), .hit_vec(dup_vec)
   );

   vb_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
      .vec(lk_vec), .idx(lk_idx), .any(lk_any)
   );

   vb_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_dup_enc (
      .vec(dup_vec), .idx(dup_idx), .any(dup_any)
   );

   assign full     = (cnt_q == CNT_W'(NUM_ENTRIES));
   assign lk_hit   = lk_any;
   assign lk_data  = lk_any ? q_data[lk_idx] : '0;
   assign swap_ack = ins_valid & swap & lk_any;

   always_comb begin
      op     = VB_HOLD;
      rm_idx = '0;
      if (swap_ack) begin
         op     = VB_REPLACE;
         rm_idx = lk_idx;
      end else if (ins_valid && dup_any) begin
         op     = VB_REPLACE;
         rm_idx = dup_idx;
      end else if (ins_valid) begin
         op = full ? VB_ROTATE : VB_APPEND;
      end
   end

   vb_queue #(
      .N(NUM_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n), .op(op), .rm_idx(rm_idx),
      .new_addr(ins_addr), .new_data(ins_data),
      .q_addr(q_addr), .q_data(q_data), .q_vld(q_vld), .q_cnt(cnt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_valid <= 1'b0;
      else        ev_valid <= (op == VB_ROTATE);
   end

   always_ff @(posedge clk) begin
      if (op == VB_ROTATE) begin
         ev_addr <= q_addr[0];
         ev_data <= q_data[0];
      end
   end

endmodule

// File: rtl/vb_chk.sv
module vb_chk #(
   parameter int N     = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_valid,
   input logic             lk_valid,
   input logic             lk_hit,
   input logic             swap_ack,
   input logic             ev_valid,
   input logic             dup_any,
   input logic [N-1:0]     lk_vec,
   input logic [CNT_W-1:0] cnt
);

   // R4
   occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(N));

   // R2
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> $stable(cnt));

   // R4
   grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && !dup_any && !swap_ack && cnt < CNT_W'(N) |=> cnt == $past(cnt) + CNT_W'(1));

   // R5
   full_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && !dup_any && !swap_ack && cnt == CNT_W'(N) |=> ev_valid);

   // R5
   evict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> $past(ins_valid));

   // R6
   dup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && dup_any |=> $stable(cnt) && !ev_valid);

   // R7
   swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap_ack |=> $stable(cnt) && !ev_valid);

   // R10
   probe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit && !swap_ack);

endmodule

bind victim_buffer vb_chk #(.N(NUM_ENTRIES), .CNT_W(CNT_W)) u_vb_chk (
   .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .lk_valid(lk_valid),
   .lk_hit(lk_hit), .swap_ack(swap_ack), .ev_valid(ev_valid),
   .dup_any(dup_any), .lk_vec(lk_vec), .cnt(cnt_q)
);

// File: tb/tb_victim_buffer.sv
`timescale 1ns/100ps
module tb_victim_buffer;

   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0;
   logic          swap = 1'b0;
   logic [AW-1:0] ins_addr = '0;
   logic [DW-1:0] ins_data = '0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_hit;
   logic [DW-1:0] lk_data;
   logic          swap_ack;
   logic          ev_valid;
   logic [AW-1:0] ev_addr;
   logic [DW-1:0] ev_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   victim_buffer #(.NUM_ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .swap(swap),
      .ins_addr(ins_addr), .ins_data(ins_data), .lk_valid(lk_valid),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
      .swap_ack(swap_ack), .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data)
   );

   typedef struct packed {
      bit          iv;
      bit          sw;
      bit [AW-1:0] ia;
      bit [DW-1:0] id;
      bit          lv;
      bit [AW-1:0] la;
      bit          xh;
      bit [DW-1:0] xd;
      bit          xa;
      bit          xev;
      bit [AW-1:0] xea;
      bit [DW-1:0] xed;
   } vec_t;

   // xev/xea/xed: eviction caused by the previous row, seen before this row is driven
   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{0,0,8'h00,16'h0000, 1,8'h10, 0,16'h0000,0, 0,8'h00,16'h0000},
      '{1,0,8'h10,16'h1010, 1,8'h10, 0,16'h0000,0, 0,8'h00,16'h0000},
      '{1,0,8'h20,16'h2020, 1,8'h10, 1,16'h1010,0, 0,8'h00,16'h0000},
      '{1,0,8'h30,16'h3030, 1,8'h20, 1,16'h2020,0, 0,8'h00,16'h0000},
      '{1,0,8'h40,16'h4040, 1,8'h90, 0,16'h0000,0, 0,8'h00,16'h0000},
      '{1,0,8'h90,16'h9090, 1,8'h30, 1,16'h3030,0, 0,8'h00,16'h0000},
      '{0,0,8'h00,16'h0000, 1,8'h10, 0,16'h0000,0, 1,8'h10,16'h1010},
      '{0,0,8'h00,16'h0000, 1,8'h90, 1,16'h9090,0, 0,8'h00,16'h0000},
      '{1,0,8'h30,16'hBEEF, 1,8'h30, 1,16'h3030,0, 0,8'h00,16'h0000},
      '{0,0,8'h00,16'h0000, 1,8'h30, 1,16'hBEEF,0, 0,8'h00,16'h0000},
      '{1,1,8'h55,16'h5555, 1,8'h40, 1,16'h4040,1, 0,8'h00,16'h0000},
      '{0,0,8'h00,16'h0000, 1,8'h40, 0,16'h0000,0, 0,8'h00,16'h0000},
      '{0,0,8'h00,16'h0000, 1,8'h55, 1,16'h5555,0, 0,8'h00,16'h0000},
      '{1,1,8'h66,16'h6666, 1,8'h77, 0,16'h0000,0, 0,8'h00,16'h0000},
      '{0,0,8'h00,16'h0000, 1,8'h66, 1,16'h6666,0, 1,8'h20,16'h2020},
      '{1,0,8'h11,16'h1111, 0,8'h90, 0,16'h0000,0, 0,8'h00,16'h0000},
      '{0,0,8'h00,16'h0000, 1,8'h30, 1,16'hBEEF,0, 1,8'h90,16'h9090},
      '{1,0,8'h12,16'h1212, 1,8'h55, 1,16'h5555,0, 0,8'h00,16'h0000},
      '{0,0,8'h00,16'h0000, 1,8'h55, 1,16'h5555,0, 1,8'h30,16'hBEEF}
   };

   function automatic string tag_of(input int k);
      case (k)
         0:        return "R1";
         1:        return "R4";
         2, 3:     return "R3";
         4:        return "R9";
         5, 6, 7:  return "R5";
         8, 9:     return "R6";
         10, 11, 12: return "R7";
         13, 14:   return "R8";
         15:       return "R10";
         default:  return "R5";
      endcase
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      lk_valid = 1'b1;
      lk_addr  = 8'h10;
      #1;
      check("R1", "ev_valid after reset", ev_valid, 0);
      check("R1", "lk_hit after reset", lk_hit, 0);

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         check(tag_of(k), "ev_valid", ev_valid, VEC[k].xev);
         if (VEC[k].xev) begin
            check("R5", "ev_addr", ev_addr, VEC[k].xea);
            check("R5", "ev_data", ev_data, VEC[k].xed);
         end
         ins_valid = VEC[k].iv;
         swap      = VEC[k].sw;
         ins_addr  = VEC[k].ia;
         ins_data  = VEC[k].id;
         lk_valid  = VEC[k].lv;
         lk_addr   = VEC[k].la;
         #1;
         check(tag_of(k), "lk_hit", lk_hit, VEC[k].xh);
         if (VEC[k].xh) check(tag_of(k), "lk_data", lk_data, VEC[k].xd);
         check(VEC[k].sw ? "R7" : tag_of(k), "swap_ack", swap_ack, VEC[k].xa);
      end

      // R10: swap request with a disabled probe of a held address
      @(negedge clk);
      ins_valid = 1'b1; swap = 1'b1; ins_addr = 8'h13; ins_data = 16'h1313;
      lk_valid = 1'b0; lk_addr = 8'h55;
      #1;
      check("R10", "lk_hit with probe off", lk_hit, 0);
      check("R10", "swap_ack with probe off", swap_ack, 0);
      @(negedge clk);
      ins_valid = 1'b0; swap = 1'b0; lk_valid = 1'b1; lk_addr = 8'h55;
      #1;
      check("R8", "ev_valid after fallback insert", ev_valid, 1);
      check("R8", "ev_addr after fallback insert", ev_addr, 8'h55);

      // R1: reset in mid-run empties the buffer
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      lk_addr = 8'h66;
      #1;
      check("R1", "lk_hit after second reset", lk_hit, 0);
      check("R1", "ev_valid after second reset", ev_valid, 0);
      @(negedge clk);
      ins_valid = 1'b1; ins_addr = 8'hA0; ins_data = 16'hA0A0;
      @(negedge clk);
      ins_valid = 1'b0; lk_addr = 8'hA0;
      #1;
      check("R4", "lk_hit after insert into empty", lk_hit, 1);
      check("R4", "lk_data after insert into empty", lk_data, 16'hA0A0);
      check("R4", "ev_valid after insert into empty", ev_valid, 0);

      done = 1'b1;
      finish_run();
   end

endmodule